// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block multiplies two unsigned operands with one adder that it reuses over several clock cycles. A start request captures the multiplicand A and the multiplier B and clears the accumulator. After that, each cycle adds either A or zero into the upper half of the accumulator, depending on the lowest bit of B. The accumulator and B then move right by one place together. B shifts itself between loads, so the multiplier needs no separate bit-select path.

With the default WIDTH of 8, one product takes nine cycles: one cycle to load and eight add-shift steps. The last step finishes the shift, so the final partial sum lands in the upper byte. A one-cycle done pulse marks the point where the product is valid. The product then holds until the next accepted start or a restart.

The block has no back-pressure. `busy` low means ready, and a start seen while busy is dropped, not queued. The result is not consumed by a handshake: it simply stays on `product` while the block is idle.

Top module: `shiftadd_mult`

## Requirements
- R1: When `start` is high and `busy` is low at a rising edge, A and B are captured, `product` reads 0 and `busy` reads 1 in the following cycle.
- R2: While `busy` is high, `start`, `a_in` and `b_in` have no effect: the product finishes from the operands captured at acceptance, and no second operation begins afterwards.
- R3: `busy` stays high for exactly 8 cycles after acceptance. In the 9th cycle after the accepting edge, `done` is high for one cycle and `busy` is low.
- R4: When `done` is high, `product` equals the full unsigned 2×WIDTH-bit product A·B, with the adder carry kept (for example 255·255 = 65025).
- R5: While `busy` is low and no start is accepted, `product` holds its value.
- R6: A synchronous `restart` clears `busy`, `done` and `product` at the next edge, aborts any operation in progress, and overrides a simultaneous `start`.
- R7: After k add-shift steps, `product` equals (A · (B mod 2^k)) · 2^(WIDTH−k). A step whose multiplier bit is 0 only shifts the accumulator right by one place.
- R8: A zero operand on either side gives a product of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| restart | input | 1 | Synchronous clear and abort, active high |
| start | input | 1 | Request to begin; accepted only while idle |
| a_in | input | WIDTH | Multiplicand, captured at acceptance |
| b_in | input | WIDTH | Multiplier, captured at acceptance |
| busy | output | 1 | High while add-shift steps are running; low means ready |
| done | output | 1 | One-cycle pulse when the product becomes valid |
| product | output | 2*WIDTH | Accumulator; holds the final product while idle |

## Verification
The bench builds the block at its default WIDTH of 8, so every partial sum fits in an integer reference model. The model predicts the accumulator after each step in closed form, without stepping a shifter. At this width the all-ones case drives the adder carry into bit 15. Walking-bit and alternating operands exercise every step that skips an add, and zero operands are covered on both sides. Mid-run start requests, restarts during a run, a restart that coincides with a start, and back-to-back starts issued in the cycle that carries done all fall within this width.

// File: rtl/shm_pkg.sv
package shm_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/shm_ctrl.sv
module shm_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic restart,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  import shm_pkg::*;

  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);
  localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(WIDTH);

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;

  assign busy = (state == SEQ_RUN);
  assign step = busy;
  assign load = start && !busy && !restart;

  always_ff @(posedge clk) begin
    if (restart) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        SEQ_IDLE: begin
          if (start) begin
            state <= SEQ_RUN;
            cnt   <= '0;
          end
        end
        SEQ_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_STEP) begin
            state <= SEQ_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // R3: done lasts exactly one cycle
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (restart)
    done |=> !done);
  // R3: the final step is followed by done with busy dropped
  assert_done_after_last_R3: assert property (@(posedge clk) disable iff (restart)
    (step && cnt == LAST_STEP) |=> (done && !busy));
  // R3: the counter never passes its last value
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (restart)
    cnt <= CNT_MAX);
  // R2: a start while running never raises a load
  assert_no_load_busy_R2: assert property (@(posedge clk) disable iff (restart)
    busy |-> !load);
endmodule

// File: rtl/shm_breg.sv
module shm_breg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             restart,
  input  logic             latch,
  input  logic             load_sel,
  input  logic [WIDTH-1:0] d,
  output logic             lsb
);
  logic [WIDTH-1:0] q;

  always_ff @(posedge clk) begin
    if (restart)
      q <= '0;
    else if (latch)
      q <= load_sel ? d : (q >> 1);
  end

  assign lsb = q[0];

  // R7: a latch without load-select moves the multiplier right one place
  assert_b_shift_R7: assert property (@(posedge clk) disable iff (restart)
    (latch && !load_sel) |=> (q == ($past(q) >> 1)));
  // R2: the multiplier only changes when latched
  assert_b_hold_R2: assert property (@(posedge clk) disable iff (restart)
    !latch |=> $stable(q));
endmodule

// File: rtl/shm_accum.sv
module shm_accum #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               restart,
  input  logic               clr,
  input  logic               step,
  input  logic               add_en,
  input  logic [WIDTH-1:0]   mcand,
  output logic [2*WIDTH-1:0] acc
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] addend;
  logic [WIDTH:0]   sum;

  assign addend = add_en ? mcand : '0;
  assign sum    = {1'b0, acc[PW-1:WIDTH]} + {1'b0, addend};

  always_ff @(posedge clk) begin
    if (restart || clr)
      acc <= '0;
    else if (step)
      acc <= {sum, acc[WIDTH-1:1]};
  end

  // R1: the clear leaves the accumulator at zero
  assert_clear_zero_R1: assert property (@(posedge clk) disable iff (restart)
    (clr && !step) |=> (acc == '0));
  // R7: a step with a zero multiplier bit is a pure right shift
  assert_skip_add_R7: assert property (@(posedge clk) disable iff (restart)
    (step && !clr && !add_en) |=> (acc == ($past(acc) >> 1)));
endmodule

// File: rtl/shiftadd_mult.sv
module shiftadd_mult #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               restart,
  input  logic               start,
  input  logic [WIDTH-1:0]   a_in,
  input  logic [WIDTH-1:0]   b_in,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  logic             load;
  logic             step;
  logic             b_lsb;
  logic [WIDTH-1:0] a_q;

  shm_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .restart (restart),
    .start   (start),
    .load    (load),
    .step    (step),
    .busy    (busy),
    .done    (done)
  );

  always_ff @(posedge clk) begin
    if (restart)
      a_q <= '0;
    else if (load)
      a_q <= a_in;
  end

  shm_breg #(.WIDTH(WIDTH)) u_breg (
    .clk      (clk),
    .restart  (restart),
    .latch    (load | step),
    .load_sel (load),
    .d        (b_in),
    .lsb      (b_lsb)
  );

  shm_accum #(.WIDTH(WIDTH)) u_accum (
    .clk     (clk),
    .restart (restart),
    .clr     (load),
    .step    (step),
    .add_en  (b_lsb),
    .mcand   (a_q),
    .acc     (product)
  );

  // R2: the multiplicand stays put across every running step
  assert_a_stable_R2: assert property (@(posedge clk) disable iff (restart)
    step |=> $stable(a_q));
  // R5: an idle block without a start keeps its product
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (restart)
    (!busy && !start) |=> $stable(product));
  // R1: an accepted start makes the block busy with a cleared product
  assert_accept_R1: assert property (@(posedge clk) disable iff (restart)
    (start && !busy) |=> (busy && product == '0));
  // R6: restart empties the block at the next edge
  assert_restart_clear_R6: assert property (@(posedge clk)
    restart |=> (!busy && !done && product == '0));
endmodule

// File: tb/shiftadd_mult_test.sv
module shiftadd_mult_test;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           restart = 1'b1;
  logic           start = 1'b0;
  logic [W-1:0]   a_in = '0;
  logic [W-1:0]   b_in = '0;
  logic           busy;
  logic           done;
  logic [2*W-1:0] product;

  always #10 clk = ~clk;

  shiftadd_mult #(.WIDTH(W)) uut (
    .clk(clk), .restart(restart), .start(start), .a_in(a_in), .b_in(b_in),
    .busy(busy), .done(done), .product(product)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit cmp_en = 1'b0;

  // behavioural reference
  bit          m_busy = 1'b0;
  bit          m_done = 1'b0;
  int          m_k = 0;
  int unsigned m_a = 0;
  int unsigned m_b = 0;
  int unsigned m_prod = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (restart) begin
      m_busy = 1'b0; m_done = 1'b0; m_k = 0; m_prod = 0;
    end else if (m_busy) begin
      m_k++;
      m_prod = (m_a * (m_b % (32'd1 << m_k))) << (W - m_k);
      m_done = (m_k == W);
      if (m_k == W) m_busy = 1'b0;
    end else begin
      m_done = 1'b0;
      if (start) begin
        m_busy = 1'b1; m_k = 0; m_a = a_in; m_b = b_in; m_prod = 0;
      end
    end
    if (cyc > 50000) begin
      tests++; fails++;
      $display("FAIL R3 watchdog actual=%0d expected=%0d", cyc, 50000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(busy === m_busy, "R3 busy vs model", busy, m_busy);
      chk(done === m_done, "R3 done vs model", done, m_done);
      chk(product === 16'(m_prod), m_busy ? "R7 partial product" : (m_done ? "R4 final product" : "R5 idle product"),
          product, m_prod);
    end
  end

  task automatic do_op(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    a_in = a; b_in = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0; a_in = ~a; b_in = ~b;
    repeat (7) @(negedge clk);
    chk(busy === 1'b1 && done === 1'b0, {req, " R3 still running"}, {busy, done}, 2'b10);
    @(negedge clk);
    chk(done === 1'b1 && busy === 1'b0, {req, " R3 done timing"}, {busy, done}, 2'b01);
    chk(product === 16'(a) * 16'(b), {req, " product"}, product, 16'(a) * 16'(b));
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && product === '0, "R6 reset state", product, 0);
    restart = 1'b0;
    cmp_en = 1'b1;
    @(negedge clk);

    do_op(8'd0,   8'hB7, "R8 zero A");
    do_op(8'hC3,  8'd0,  "R8 zero B");
    do_op(8'hFF,  8'hFF, "R4 carry max");
    do_op(8'd1,   8'd1,  "R4 unit");
    do_op(8'h80,  8'h02, "R7 walking bit");
    do_op(8'hAA,  8'h55, "R7 alternating");
    do_op(8'd13,  8'd11, "R4 small");
    for (int i = 0; i < 30; i++) do_op(8'($urandom), 8'($urandom), "R4 random");

    // R5: idle hold with inputs wandering
    a_in = 8'h3C; b_in = 8'h77;
    repeat (5) @(negedge clk);
    chk(product === 16'(8'd13) * 16'(8'd11) || !busy, "R5 idle hold", product, product);

    // R2: start during a run is dropped
    a_in = 8'd200; b_in = 8'd3; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (2) @(negedge clk);
    a_in = 8'd7; b_in = 8'd9; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    chk(done === 1'b1 && product === 16'd600, "R2 ignored start", product, 600);
    @(negedge clk);
    chk(busy === 1'b0, "R2 no queued op", busy, 0);

    // R6: abort mid-run, restart beats start
    a_in = 8'd9; b_in = 8'd9; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    restart = 1'b1; start = 1'b1;
    @(negedge clk);
    restart = 1'b0; start = 1'b0;
    chk(busy === 1'b0 && done === 1'b0 && product === '0, "R6 abort", product, 0);
    @(negedge clk);
    chk(busy === 1'b0, "R6 start overridden", busy, 0);

    // R1: acceptance clears product
    a_in = 8'd5; b_in = 8'd6; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy === 1'b1 && product === '0, "R1 accept", product, 0);
    repeat (8) @(negedge clk);
    chk(product === 16'd30, "R4 after accept", product, 30);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule